// File: doc/BRIEF.md
# Parallel Display Bus Master (8080-style)

This block lets on-chip logic talk to an external display controller over an asynchronous parallel bus with active-low chip select, read strobe and write strobe, a register-select line that tells commands from data, and a shared data bus. The bus is 8 or 16 bits wide, chosen at build time. The host side issues one operation at a time through a request/busy/done handshake with a two-bit operation code. The four operations are index write, data write, status read and data read.

Each bus access runs as a sequence of equal half-periods. Chip select falls and register-select settles, then each beat holds its strobe low for one half-period and high for one half-period, and then chip select rises. The half-period length is half the value on the divider input, sampled when the request is accepted, with a floor of one clock. Data reads always begin with a dummy beat inside the same chip-select window. On an 8-bit bus a 16-bit word travels as two byte beats. On a 16-bit bus the bytes of a returned word are swapped.

Top module: `p80_master`

## Requirements
- R1: While in reset and whenever idle, chip select, read strobe and write strobe are high, register-select is high, the data bus output enable is low, and busy and done are low.
- R2: A strobe goes low only while chip select is low, and read and write strobes are never low together. During strobes register-select is low for index writes and status reads and high for data accesses.
- R3: Op code 0 (index write) emits exactly one write beat carrying the low DW bits of the write word. Register-select is low for that beat and returns high before chip select rises.
- R4: Op code 2 (status read) emits exactly one read beat and no write beat. The result is the sampled byte on an 8-bit bus, or bits 15:8 of the sampled word on a 16-bit bus, zero-extended.
- R5: Op code 3 (data read) emits two read beats inside one chip-select window. On an 8-bit bus a wide read returns {first beat, second beat} and a narrow read returns the second beat zero-extended.
- R6: On a 16-bit bus a wide data read returns the second beat with its bytes swapped, and a narrow data read returns bits 15:8 of the second beat zero-extended.
- R7: Op code 1 (data write) with the wide flag on an 8-bit bus sends bits 15:8 and then bits 7:0 in one chip-select window. On a 16-bit bus it sends the whole word in one beat.
- R8: Every strobe low time lasts max(div/2, 1) clock cycles, with div taken when the request is accepted.
- R9: The data bus output enable stays low for every read operation and is high only while chip select is low during a write operation.
- R10: A request is accepted only while busy is low, and busy rises on the next cycle. Requests made while busy are ignored. Each operation gives exactly one single-cycle done pulse, which carries the read result.
- R11: Between back-to-back operations chip select stays high for at least one half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | DIV_W | Clock divider; half-period = max(div/2,1) cycles |
| req_i | input | 1 | Operation request, taken when busy is low |
| op_i | input | 2 | 0 index write, 1 data write, 2 status read, 3 data read |
| wide_i | input | 1 | Data operation carries a 16-bit word |
| wdata_i | input | 16 | Write word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, valid with done |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rs_o | output | 1 | Register select: low command/status, high data |
| bus_oe_o | output | 1 | Data bus output enable |
| bus_out_o | output | DATA_W | Data bus output value |
| bus_in_i | input | DATA_W | Data bus input value |

## Verification
The assertions check on every cycle that the idle lines are quiet and that the strobes are exclusive and confined to chip select. They also check that the bus is never driven during a read strobe, that done is a single pulse, that busy follows acceptance and that a chip-select rise is followed by a high cycle. Only the bench scenarios can show the beat counts per operation, the byte order and swap of assembled results, the high-then-low byte order of wide writes, the strobe length for several divider values, the rule that register-select rises before chip select, and the fact that a request made while busy starts no second window.

// File: rtl/p80_pkg.sv
// Shared definitions for the parallel display bus master.
// Op code bit 1 marks a read, bit 0 marks a data (not command/status) access.
package p80_pkg;
    localparam logic [1:0] OP_IDX_WR  = 2'd0;
    localparam logic [1:0] OP_DAT_WR  = 2'd1;
    localparam logic [1:0] OP_STAT_RD = 2'd2;
    localparam logic [1:0] OP_DAT_RD  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_TAIL  = 3'd4,
        ST_GAP   = 3'd5
    } p80_state_e;
endpackage

// File: rtl/p80_halfper.sv
// Half-period timer: latches max(div/2,1) on load and pulses tick at the
// end of every half-period. Assumes load coincides with a phase start.
module p80_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_raw;

    assign half_raw = div >> 1;
    assign tick     = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, half_q};

    // Latch the half-period length at request acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            half_q <= DIV_W'(1);
        else if (load)
            half_q <= (half_raw == '0) ? DIV_W'(1) : half_raw;
    end

    // Count cycles inside the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || load || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/p80_rdcap.sv
// Read capture and assembly: stores read beats on the strobe release edge
// and forms the 16-bit result by bus width (byte join or byte swap).
module p80_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              is_data,
    input  logic              wide,
    output logic [15:0]       result
);
    logic [DATA_W-1:0] last_q;

    // Keep the most recently sampled beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (cap)
            last_q <= bus_in;
    end

    generate
        if (DATA_W == 8) begin : g_b8
            logic [7:0] prev_q;
            // Keep the beat before the last one (the dummy on data reads).
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prev_q <= '0;
                else if (cap)
                    prev_q <= last_q;
            end
            assign result = (is_data && wide) ? {prev_q, last_q} : {8'h00, last_q};
        end else begin : g_b16
            assign result = (is_data && wide) ? {last_q[7:0], last_q[15:8]}
                                              : {8'h00, last_q[15:8]};
        end
    endgenerate
endmodule

// File: rtl/p80_master.sv
// Parallel (8080-style) display bus master. One operation per request;
// phases SETUP, beats of LOW/HIGH, TAIL and GAP each last one half-period.
// Assumes the bus is 8 or 16 bits wide and the peer answers within a half-period.
module p80_master
    import p80_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              req_i,
    input  logic [1:0]        op_i,
    input  logic              wide_i,
    input  logic [15:0]       wdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [15:0]       rdata_o,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              rs_o,
    output logic              bus_oe_o,
    output logic [DATA_W-1:0] bus_out_o,
    input  logic [DATA_W-1:0] bus_in_i
);
    p80_state_e        st_q;
    logic [1:0]        op_q;
    logic              wide_q;
    logic [15:0]       wdata_q;
    logic              beat_q;
    logic              done_q;
    logic [15:0]       rdata_q;
    logic              accept, tick, is_rd, is_data, two_beats, last_beat, cap;
    logic [DATA_W-1:0] wbeat;
    logic [15:0]       asm_res;

    assign accept    = req_i && (st_q == ST_IDLE);
    assign is_rd     = op_q[1];
    assign is_data   = op_q[0];
    assign last_beat = two_beats ? beat_q : 1'b1;
    assign cap       = tick && (st_q == ST_LOW) && is_rd;

    generate
        if (DATA_W == 8) begin : g_w8
            assign two_beats = is_data && (is_rd || wide_q);
            assign wbeat = (wide_q && is_data && !beat_q) ? wdata_q[15:8] : wdata_q[7:0];
        end else begin : g_w16
            assign two_beats = is_data && is_rd;
            assign wbeat = wdata_q;
        end
    endgenerate

    p80_halfper #(.DIV_W(DIV_W)) i_halfper (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .div  (div_i),
        .tick (tick)
    );

    p80_rdcap #(.DATA_W(DATA_W)) i_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .bus_in (bus_in_i),
        .is_data(is_data),
        .wide   (wide_q),
        .result (asm_res)
    );

    // Capture the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_IDX_WR;
            wide_q  <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            op_q    <= op_i;
            wide_q  <= wide_i;
            wdata_q <= wdata_i;
        end
    end

    // Phase sequencer, beat index, done pulse and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            beat_q  <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                st_q   <= ST_SETUP;
                beat_q <= 1'b0;
            end else if (tick) begin
                unique case (st_q)
                    ST_SETUP: st_q <= ST_LOW;
                    ST_LOW:   st_q <= ST_HIGH;
                    ST_HIGH: begin
                        if (last_beat) begin
                            st_q <= ST_TAIL;
                        end else begin
                            st_q   <= ST_LOW;
                            beat_q <= 1'b1;
                        end
                    end
                    ST_TAIL: begin
                        st_q    <= ST_GAP;
                        done_q  <= 1'b1;
                        rdata_q <= is_rd ? asm_res : 16'h0000;
                    end
                    ST_GAP:  st_q <= ST_IDLE;
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Bus pins decoded from the current phase.
    always_comb begin
        busy_o    = (st_q != ST_IDLE);
        cs_n_o    = (st_q == ST_IDLE) || (st_q == ST_GAP);
        rd_n_o    = !((st_q == ST_LOW) && is_rd);
        wr_n_o    = !((st_q == ST_LOW) && !is_rd);
        rs_o      = ((st_q == ST_SETUP) || (st_q == ST_LOW) || (st_q == ST_HIGH)) ? is_data : 1'b1;
        bus_oe_o  = !is_rd && !cs_n_o;
        bus_out_o = bus_oe_o ? wbeat : '0;
    end

    assign done_o  = done_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/p80_master_chk.sv
// Protocol checker for p80_master, bound to every instance.
module p80_master_chk (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic busy_o,
    input logic done_o,
    input logic cs_n_o,
    input logic rd_n_o,
    input logic wr_n_o,
    input logic rs_o,
    input logic bus_oe_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && rd_n_o && wr_n_o && rs_o && !bus_oe_o && !done_o)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o)); // R2
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) |-> !cs_n_o); // R2
    AST_RS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o && $past(!wr_n_o)) |-> $stable(rs_o)); // R3
    AST_RD_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !bus_oe_o); // R9
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && busy_o)); // R10
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> busy_o); // R10
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> cs_n_o); // R11
endmodule

bind p80_master p80_master_chk i_p80_master_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .cs_n_o  (cs_n_o),
    .rd_n_o  (rd_n_o),
    .wr_n_o  (wr_n_o),
    .rs_o    (rs_o),
    .bus_oe_o(bus_oe_o)
);

// File: tb/test_p80_master.sv
// Display-side model: logs write beats, serves read beats, measures timing.
module p80_disp_model #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          rs,
    input  logic          oe,
    input  logic [DW-1:0] dout,
    input  logic [15:0]   v0,
    input  logic [15:0]   v1,
    output logic [DW-1:0] din,
    output logic [3:0]    wcnt,
    output logic [3:0]    rcnt,
    output logic [3:0]    ncs,
    output logic [15:0]   w0,
    output logic [15:0]   w1,
    output logic          wrs0,
    output logic          rrs0,
    output logic [7:0]    lowlen,
    output logic [7:0]    mingap,
    output logic          bad
);
    logic          prev_wr, prev_rd, prev_cs, prev_rs, seen;
    logic [DW-1:0] cur_w;
    logic          cur_wrs, cur_rrs;
    logic [7:0]    lowrun, gaprun;

    assign din = (rcnt == 4'd0) ? v0[DW-1:0] : v1[DW-1:0];

    always @(negedge clk) begin
        if (clr) begin
            wcnt <= 0; rcnt <= 0; ncs <= 0; w0 <= 0; w1 <= 0;
            wrs0 <= 1; rrs0 <= 1; lowlen <= 0; mingap <= 8'hff; bad <= 0;
            prev_wr <= 1; prev_rd <= 1; prev_cs <= 1; prev_rs <= 1; seen <= 0;
            cur_w <= 0; cur_wrs <= 1; cur_rrs <= 1; lowrun <= 0; gaprun <= 0;
        end else begin
            if (!wr_n) begin cur_w <= dout; cur_wrs <= rs; end
            if (!rd_n) cur_rrs <= rs;
            if (!prev_wr && wr_n) begin
                if (wcnt == 0) begin w0 <= 16'(cur_w); wrs0 <= cur_wrs; end
                else w1 <= 16'(cur_w);
                wcnt <= wcnt + 1;
            end
            if (!prev_rd && rd_n) begin
                if (rcnt == 0) rrs0 <= cur_rrs;
                rcnt <= rcnt + 1;
            end
            if (!rd_n || !wr_n) lowrun <= lowrun + 1;
            else if (lowrun != 0) begin lowlen <= lowrun; lowrun <= 0; end
            if (prev_cs && !cs_n) begin
                ncs <= ncs + 1;
                if (seen && gaprun < mingap) mingap <= gaprun;
                seen <= 1;
            end
            if (cs_n) gaprun <= gaprun + 1; else gaprun <= 0;
            if (!rd_n && oe) bad <= 1;
            if (!prev_cs && cs_n && !prev_rs) bad <= 1;
            prev_wr <= wr_n; prev_rd <= rd_n; prev_cs <= cs_n; prev_rs <= rs;
        end
    end
endmodule

// Directed bench: one 16-bit bus instance and one 8-bit bus instance.
module test_p80_master;
    localparam int CLK_PERIOD = 10;

    logic clk = 0;
    logic rst_n = 0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req [2];
    logic [1:0]  op [2];
    logic        wide [2];
    logic [15:0] wdata [2];
    logic [7:0]  div [2];
    logic        clr [2];
    logic [15:0] v0 [2];
    logic [15:0] v1 [2];
    logic        busy [2], done [2], cs_n [2], rd_n [2], wr_n [2], rs [2], oe [2];
    logic [15:0] rdata [2];
    logic [15:0] bo16, bi16;
    logic [7:0]  bo8, bi8;
    logic [3:0]  wcnt [2], rcnt [2], ncs [2];
    logic [15:0] w0 [2], w1 [2];
    logic        wrs0 [2], rrs0 [2], bad [2];
    logic [7:0]  lowlen [2], mingap [2];

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    p80_master #(.DATA_W(16), .DIV_W(8)) i_p80_master (
        .clk(clk), .rst_n(rst_n), .div_i(div[0]), .req_i(req[0]), .op_i(op[0]),
        .wide_i(wide[0]), .wdata_i(wdata[0]), .busy_o(busy[0]), .done_o(done[0]),
        .rdata_o(rdata[0]), .cs_n_o(cs_n[0]), .rd_n_o(rd_n[0]), .wr_n_o(wr_n[0]),
        .rs_o(rs[0]), .bus_oe_o(oe[0]), .bus_out_o(bo16), .bus_in_i(bi16)
    );
    p80_master #(.DATA_W(8), .DIV_W(8)) i_p80_master_b8 (
        .clk(clk), .rst_n(rst_n), .div_i(div[1]), .req_i(req[1]), .op_i(op[1]),
        .wide_i(wide[1]), .wdata_i(wdata[1]), .busy_o(busy[1]), .done_o(done[1]),
        .rdata_o(rdata[1]), .cs_n_o(cs_n[1]), .rd_n_o(rd_n[1]), .wr_n_o(wr_n[1]),
        .rs_o(rs[1]), .bus_oe_o(oe[1]), .bus_out_o(bo8), .bus_in_i(bi8)
    );
    p80_disp_model #(.DW(16)) i_m16 (
        .clk(clk), .clr(clr[0]), .cs_n(cs_n[0]), .rd_n(rd_n[0]), .wr_n(wr_n[0]),
        .rs(rs[0]), .oe(oe[0]), .dout(bo16), .v0(v0[0]), .v1(v1[0]), .din(bi16),
        .wcnt(wcnt[0]), .rcnt(rcnt[0]), .ncs(ncs[0]), .w0(w0[0]), .w1(w1[0]),
        .wrs0(wrs0[0]), .rrs0(rrs0[0]), .lowlen(lowlen[0]), .mingap(mingap[0]), .bad(bad[0])
    );
    p80_disp_model #(.DW(8)) i_m8 (
        .clk(clk), .clr(clr[1]), .cs_n(cs_n[1]), .rd_n(rd_n[1]), .wr_n(wr_n[1]),
        .rs(rs[1]), .oe(oe[1]), .dout(bo8), .v0(v0[1]), .v1(v1[1]), .din(bi8),
        .wcnt(wcnt[1]), .rcnt(rcnt[1]), .ncs(ncs[1]), .w0(w0[1]), .w1(w1[1]),
        .wrs0(wrs0[1]), .rrs0(rrs0[1]), .lowlen(lowlen[1]), .mingap(mingap[1]), .bad(bad[1])
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Run one operation on instance s; optionally poke a request mid-operation.
    task automatic run(input int s, input logic [1:0] o, input logic w, input logic [15:0] d,
                       input logic [7:0] dv, input bit poke,
                       output logic [15:0] res, output int dcnt);
        int n = 0;
        dcnt = 0;
        res = 16'hxxxx;
        @(negedge clk);
        clr[s] = 1;
        @(negedge clk);
        clr[s] = 0;
        op[s] = o; wide[s] = w; wdata[s] = d; div[s] = dv; req[s] = 1;
        @(negedge clk);
        req[s] = 0;
        while (busy[s]) begin
            if (done[s]) begin dcnt++; res = rdata[s]; end
            n++;
            if (poke && n == 3) begin req[s] = 1; op[s] = ~o; wdata[s] = ~d; end
            if (poke && n == 4) req[s] = 0;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        for (int s = 0; s < 2; s++) begin
            check(cs_n[s] && rd_n[s] && wr_n[s] && rs[s], "R1 idle strobes", {cs_n[s], rd_n[s], wr_n[s], rs[s]}, 4'hf);
            check(!oe[s] && !busy[s] && !done[s], "R1 idle oe/busy/done", {oe[s], busy[s], done[s]}, 0);
        end
    endtask

    task automatic t_index_write();
        logic [15:0] r; int dc;
        run(0, 2'd0, 1'b0, 16'h3CA5, 8'd4, 0, r, dc);
        check(wcnt[0] == 1 && rcnt[0] == 0, "R3 beats b16", {wcnt[0], rcnt[0]}, {4'd1, 4'd0});
        check(w0[0] == 16'h3CA5 && !wrs0[0], "R3 index b16", {wrs0[0], w0[0]}, {1'b0, 16'h3CA5});
        check(!bad[0] && ncs[0] == 1, "R3 rs rises before cs", {bad[0], ncs[0]}, {1'b0, 4'd1});
        run(1, 2'd0, 1'b0, 16'h3CA5, 8'd4, 0, r, dc);
        check(wcnt[1] == 1 && w0[1] == 16'h00A5 && !wrs0[1], "R3 index b8", {wcnt[1], w0[1]}, {4'd1, 16'h00A5});
        check(!bad[1], "R3 rs order b8", bad[1], 0);
    endtask

    task automatic t_status_read();
        logic [15:0] r; int dc;
        v0[0] = 16'h5A3C; v1[0] = 16'h1111;
        run(0, 2'd2, 1'b0, 16'h0, 8'd4, 0, r, dc);
        check(r == 16'h005A, "R4 status b16", r, 16'h005A);
        check(rcnt[0] == 1 && wcnt[0] == 0 && !rrs0[0], "R4 beats b16", {rcnt[0], wcnt[0], rrs0[0]}, {4'd1, 4'd0, 1'b0});
        v0[1] = 16'h003C; v1[1] = 16'h0011;
        run(1, 2'd2, 1'b0, 16'h0, 8'd4, 0, r, dc);
        check(r == 16'h003C && rcnt[1] == 1 && !rrs0[1], "R4 status b8", r, 16'h003C);
    endtask

    task automatic t_data_read_b8();
        logic [15:0] r; int dc;
        v0[1] = 16'h0012; v1[1] = 16'h0034;
        run(1, 2'd3, 1'b1, 16'h0, 8'd4, 0, r, dc);
        check(r == 16'h1234, "R5 wide read b8", r, 16'h1234);
        check(rcnt[1] == 2 && ncs[1] == 1 && rrs0[1], "R5 two beats one cs", {rcnt[1], ncs[1]}, {4'd2, 4'd1});
        check(!bad[1], "R9 no drive during read b8", bad[1], 0);
        v0[1] = 16'h0099; v1[1] = 16'h0077;
        run(1, 2'd3, 1'b0, 16'h0, 8'd4, 0, r, dc);
        check(r == 16'h0077, "R5 narrow read drops dummy", r, 16'h0077);
    endtask

    task automatic t_data_read_b16();
        logic [15:0] r; int dc;
        v0[0] = 16'hDEAD; v1[0] = 16'hBEEF;
        run(0, 2'd3, 1'b1, 16'h0, 8'd4, 0, r, dc);
        check(r == 16'hEFBE, "R6 wide read swap b16", r, 16'hEFBE);
        check(rcnt[0] == 2 && ncs[0] == 1 && !bad[0], "R6 two beats b16 / R9", {rcnt[0], ncs[0], bad[0]}, {4'd2, 4'd1, 1'b0});
        run(0, 2'd3, 1'b0, 16'h0, 8'd4, 0, r, dc);
        check(r == 16'h00BE, "R6 narrow read b16", r, 16'h00BE);
    endtask

    task automatic t_data_write();
        logic [15:0] r; int dc;
        run(1, 2'd1, 1'b1, 16'hC3E1, 8'd4, 0, r, dc);
        check(wcnt[1] == 2 && ncs[1] == 1, "R7 two beats one cs b8", {wcnt[1], ncs[1]}, {4'd2, 4'd1});
        check(w0[1] == 16'h00C3 && w1[1] == 16'h00E1 && wrs0[1], "R7 high then low", {w0[1], w1[1]}, {16'h00C3, 16'h00E1});
        run(0, 2'd1, 1'b1, 16'hC3E1, 8'd4, 0, r, dc);
        check(wcnt[0] == 1 && w0[0] == 16'hC3E1 && wrs0[0], "R7 word b16", {wcnt[0], w0[0]}, {4'd1, 16'hC3E1});
    endtask

    task automatic t_timing();
        logic [15:0] r; int dc;
        run(0, 2'd0, 1'b0, 16'h0001, 8'd6, 0, r, dc);
        check(lowlen[0] == 3, "R8 div 6", lowlen[0], 3);
        run(1, 2'd2, 1'b0, 16'h0, 8'd1, 0, r, dc);
        check(lowlen[1] == 1, "R8 div 1 floor", lowlen[1], 1);
        run(0, 2'd3, 1'b0, 16'h0, 8'd9, 0, r, dc);
        check(lowlen[0] == 4, "R8 div 9", lowlen[0], 4);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] r; int dc;
        v0[1] = 16'h00AA; v1[1] = 16'h0055;
        run(1, 2'd3, 1'b1, 16'h0, 8'd6, 1, r, dc);
        check(dc == 1, "R10 single done", dc, 1);
        check(r == 16'hAA55, "R10 result with done", r, 16'hAA55);
        check(ncs[1] == 1 && wcnt[1] == 0 && rcnt[1] == 2, "R10 busy request ignored", {ncs[1], wcnt[1], rcnt[1]}, {4'd1, 4'd0, 4'd2});
    endtask

    task automatic t_back_to_back();
        int n = 0;
        @(negedge clk); clr[0] = 1;
        @(negedge clk); clr[0] = 0;
        op[0] = 2'd0; wide[0] = 0; wdata[0] = 16'h0042; div[0] = 8'd6; req[0] = 1;
        @(negedge clk);
        while (busy[0] && n < 1000) begin n++; @(negedge clk); end
        @(negedge clk);
        req[0] = 0;
        while (busy[0] && n < 2000) begin n++; @(negedge clk); end
        repeat (4) @(negedge clk);
        #1;
        check(ncs[0] == 2, "R11 two windows", ncs[0], 2);
        check(mingap[0] >= 3, "R11 cs high gap", mingap[0], 3);
        check(wcnt[0] == 2 && w1[0] == 16'h0042, "R10 second op accepted", {wcnt[0], w1[0]}, {4'd2, 16'h0042});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            req[s] = 0; op[s] = 0; wide[s] = 0; wdata[s] = 0; div[s] = 8'd4;
            clr[s] = 1; v0[s] = 0; v1[s] = 0;
        end
        repeat (4) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        #1;
        t_reset();
        t_index_write();
        t_status_read();
        t_data_read_b8();
        t_data_read_b16();
        t_data_write();
        t_timing();
        t_busy_ignore();
        t_back_to_back();
        summary();
    end
endmodule